// File: doc/BRIEF.md
# Timer Capture/Compare/PWM Channel

One channel of a 16-bit timer. It watches a free-running counter that is shared with other channels and is generated elsewhere. The counter arrives with a flag that says whether it is counting down. A small configuration field sets what the channel does. It can release its pin, capture the counter on a chosen edge of an external input, drive the pin on a counter match, or produce edge-aligned or centre-aligned pulse-width modulation.

Software reaches the channel through a two-entry register port. Entry 0 is the control word: the pin-action bits, the mode bits, the centre-aligned select and the event flag. Entry 1 is the 16-bit channel value. In capture mode the channel value holds the last captured count. In the compare and PWM modes it holds the match value. The external input passes through a synchronizer inside the block. The channel has a pin output, a pin output-enable and one event flag, which software clears by writing 1.

Top module: `tmr_chan`

## Requirements
- R1: With centre select 0 and mode 00, action bits 01 capture on rising input edges only, 10 on falling edges only and 11 on both. A capture stores the counter value into the channel value and sets the flag, three clock edges after the input changes. An input already settled when the mode is entered raises no flag.
- R2: With action bits 00, `pin_oe` is low and `pin_out` keeps its value whatever the counter does.
- R3: Mode 01 is output compare. On a match, action bits 00 only set the flag, 01 toggle the pin, 10 drive it low and 11 drive it high.
- R4: Mode 1x is edge-aligned PWM. With action bits 10 the pin goes low on a match and high when the counter arrives at zero. With 01 or 11 it goes high on a match and low at zero. A match wins over a zero arrival in the same cycle.
- R5: Centre select 1 is centre-aligned PWM and ignores the mode bits. With action bits 10 the pin goes low on a match while counting up and high on a match while counting down. With 01 or 11 the pin does the opposite.
- R6: Entry 1 (`reg_sel`=1) reads back the last value written to it. Entry 0 reads as bits [1:0] action, [3:2] mode, bit 4 centre select and bit 7 flag, with all other bits zero. Reset clears both entries.
- R7: Every capture and every match in compare or PWM mode sets the flag. A write to entry 0 with bit 7 at 1 clears it, and a write with bit 7 at 0 leaves it alone. An event in the same cycle as a clear leaves the flag set.
- R8: A match fires only in the cycle the counter arrives at the channel value. While the counter holds that value, no further match fires.
- R9: After reset `pin_out`, `pin_oe` and `chan_flag` are 0 and the channel is in the released state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control, 1 channel value |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for the selected entry |
| cnt_val | input | 16 | Shared timer counter value |
| cnt_down | input | 1 | High while the counter is counting down |
| pin_in | input | 1 | Asynchronous external input |
| pin_out | output | 1 | Channel pin output level |
| pin_oe | output | 1 | Channel pin output-enable |
| chan_flag | output | 1 | Channel event flag |

## Verification
If the synchronizer or edge detector is corrupted, the capture comes a cycle early or late, or on the wrong edge. That shows up in the channel value and the flag three edges after the input moves. If the counter-arrival tracking is corrupted, a held counter toggles the pin again and again, or a match is missed. Both show up on `pin_out` in the cycle after the arrival. A wrong pin-action decode drives the pin to the wrong level, or turns the output-enable on in the wrong mode, one cycle after the match or zero arrival. This is checked per mode against both polarities and both count directions.

// File: rtl/tmr_chan_pkg.sv
// Shared types for the timer channel: configuration fields, decoded
// operation and register selects. Assumes counter width of at least 8.
package tmr_chan_pkg;

    localparam int CFG_W    = 5;
    localparam int FLAG_BIT = 7;
    localparam logic SEL_CTL = 1'b0;
    localparam logic SEL_VAL = 1'b1;

    typedef struct packed {
        logic       ctr;   // centre-aligned select
        logic [1:0] mode;  // mode bits
        logic [1:0] lvl;   // edge / pin-action bits
    } chan_cfg_t;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_CAPT,
        OP_OCMP,
        OP_EPWM,
        OP_CPWM
    } chan_op_e;

    // Map configuration bits to the channel operation.
    function automatic chan_op_e decode_op(input chan_cfg_t c);
        chan_op_e op;
        if (c.ctr)
            op = OP_CPWM;
        else if (c.mode == 2'b00)
            op = (c.lvl == 2'b00) ? OP_IDLE : OP_CAPT;
        else if (c.mode == 2'b01)
            op = OP_OCMP;
        else
            op = OP_EPWM;
        return op;
    endfunction

endpackage

// File: rtl/tmr_chan_sync.sv
// Input synchronizer and edge detector.
// Passes the asynchronous pin through STAGES flops, keeps one more sample
// and flags rising/falling edges of the synchronized level.
// Assumes STAGES >= 2.
module tmr_chan_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic rise,
    output logic fall
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] chain;

    // First flop samples the raw pin.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= pin_in;
    end

    // Remaining flops: synchronizer stages plus one history sample.
    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain[g] <= 1'b0;
            else        chain[g] <= chain[g-1];
        end
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];
    assign fall = ~chain[STAGES-1] & chain[STAGES];

    assert_edge_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise && fall));

endmodule

// File: rtl/tmr_chan_match.sv
// Counter arrival detector.
// Remembers the previous counter value so a match or zero fires only in
// the cycle the counter arrives, not while it holds.
module tmr_chan_match #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic [CNT_W-1:0] match_val,
    output logic             match_evt,
    output logic             zero_evt
);
    logic [CNT_W-1:0] cnt_q;
    logic             arrived;

    // Track the counter of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_val;
    end

    assign arrived   = (cnt_val != cnt_q);
    assign match_evt = arrived && (cnt_val == match_val);
    assign zero_evt  = arrived && (cnt_val == '0);

    assert_no_repeat_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |=> (!match_evt || !$stable(cnt_val)));

endmodule

// File: rtl/tmr_chan_pin.sv
// Pin output controller.
// Applies the compare / PWM pin action on match and zero events, and
// drives the output-enable from the configuration. Holds the pin level
// in released and capture operation.
module tmr_chan_pin
    import tmr_chan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  chan_op_e   op,
    input  logic [1:0] lvl,
    input  logic       match_evt,
    input  logic       zero_evt,
    input  logic       cnt_down,
    output logic       pin_out,
    output logic       pin_oe
);
    logic pin_q;
    logic pin_nxt;

    // Next pin level from the operation and this cycle's events.
    always_comb begin
        pin_nxt = pin_q;
        unique case (op)
            OP_OCMP: begin
                if (match_evt) begin
                    unique case (lvl)
                        2'b01:   pin_nxt = ~pin_q;
                        2'b10:   pin_nxt = 1'b0;
                        2'b11:   pin_nxt = 1'b1;
                        default: pin_nxt = pin_q;
                    endcase
                end
            end
            OP_EPWM: begin
                if (lvl != 2'b00) begin
                    if (match_evt)     pin_nxt = lvl[0];
                    else if (zero_evt) pin_nxt = ~lvl[0];
                end
            end
            OP_CPWM: begin
                if (lvl != 2'b00 && match_evt)
                    pin_nxt = cnt_down ? ~lvl[0] : lvl[0];
            end
            default: pin_nxt = pin_q;
        endcase
    end

    // Pin level register.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin_nxt;
    end

    assign pin_out = pin_q;
    assign pin_oe  = (lvl != 2'b00) &&
                     (op == OP_OCMP || op == OP_EPWM || op == OP_CPWM);

    assert_released_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl == 2'b00) |=> $stable(pin_q));

    assert_oc_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_OCMP && lvl == 2'b01 && match_evt) |=> (pin_q != $past(pin_q)));

    assert_epwm_high_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_EPWM && lvl == 2'b10 && match_evt) |=> !pin_q);

    assert_cpwm_down_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CPWM && lvl == 2'b10 && match_evt && cnt_down) |=> pin_q);

endmodule

// File: rtl/tmr_chan_regs.sv
// Channel register file: configuration, channel value and event flag.
// A capture takes priority over a software write of the channel value;
// a new event takes priority over a write-1 flag clear.
module tmr_chan_regs
    import tmr_chan_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             sel,
    input  logic [CNT_W-1:0] wdata,
    input  logic             capt_evt,
    input  logic             chan_evt,
    input  logic [CNT_W-1:0] cnt_val,
    output chan_cfg_t        cfg,
    output logic [CNT_W-1:0] value,
    output logic             flag,
    output logic [CNT_W-1:0] rdata
);
    localparam int PAD_W = CNT_W - 8;

    chan_cfg_t        cfg_q;
    logic [CNT_W-1:0] value_q;
    logic             flag_q;
    logic             wr_ctl;
    logic             wr_val;

    assign wr_ctl = wr_en && (sel == SEL_CTL);
    assign wr_val = wr_en && (sel == SEL_VAL);

    // Configuration register.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (wr_ctl) cfg_q <= chan_cfg_t'(wdata[CFG_W-1:0]);
    end

    // Channel value: capture first, then software write.
    always_ff @(posedge clk) begin
        if (!rst_n)        value_q <= '0;
        else if (capt_evt) value_q <= cnt_val;
        else if (wr_val)   value_q <= wdata;
    end

    // Event flag: set by events, cleared by writing 1 to its bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                        flag_q <= 1'b0;
        else if (chan_evt)                 flag_q <= 1'b1;
        else if (wr_ctl && wdata[FLAG_BIT]) flag_q <= 1'b0;
    end

    // Read mux for the selected entry.
    always_comb begin
        if (sel == SEL_VAL) rdata = value_q;
        else                rdata = {{PAD_W{1'b0}}, flag_q, 2'b00, cfg_q};
    end

    assign cfg   = cfg_q;
    assign value = value_q;
    assign flag  = flag_q;

    assert_capture_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
        capt_evt |=> (value_q == $past(cnt_val)));

    assert_flag_on_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
        chan_evt |=> flag_q);

    assert_reset_clears_R6: assert property (@(posedge clk)
        $rose(rst_n) |-> (value_q == '0 && cfg_q == '0));

endmodule

// File: rtl/tmr_chan.sv
// Timer capture / compare / PWM channel top.
// Ties the input synchronizer, counter arrival detector, register file and
// pin controller together, and forms capture and event strobes from the
// decoded operation. Assumes the counter is produced outside the block.
module tmr_chan
    import tmr_chan_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic             reg_sel,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_down,
    input  logic             pin_in,
    output logic             pin_out,
    output logic             pin_oe,
    output logic             chan_flag
);
    chan_cfg_t        cfg;
    chan_op_e         op;
    logic [CNT_W-1:0] value;
    logic             rise;
    logic             fall;
    logic             match_evt;
    logic             zero_evt;
    logic             capt_evt;
    logic             chan_evt;

    tmr_chan_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .rise   (rise),
        .fall   (fall)
    );

    tmr_chan_match #(.CNT_W(CNT_W)) match_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_val   (cnt_val),
        .match_val (value),
        .match_evt (match_evt),
        .zero_evt  (zero_evt)
    );

    tmr_chan_regs #(.CNT_W(CNT_W)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .sel      (reg_sel),
        .wdata    (reg_wdata),
        .capt_evt (capt_evt),
        .chan_evt (chan_evt),
        .cnt_val  (cnt_val),
        .cfg      (cfg),
        .value    (value),
        .flag     (chan_flag),
        .rdata    (reg_rdata)
    );

    tmr_chan_pin pin_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .lvl       (cfg.lvl),
        .match_evt (match_evt),
        .zero_evt  (zero_evt),
        .cnt_down  (cnt_down),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    // Decode the operation and form capture / event strobes.
    always_comb begin
        op       = decode_op(cfg);
        capt_evt = (op == OP_CAPT) &&
                   ((cfg.lvl[0] && rise) || (cfg.lvl[1] && fall));
        chan_evt = capt_evt ||
                   (match_evt && (op == OP_OCMP || op == OP_EPWM || op == OP_CPWM));
    end

    assert_capture_no_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CAPT) |-> !pin_oe);

endmodule

// File: tb/tmr_chan_tb_top.sv
module tmr_chan_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [15:0] cnt_val = '0;
    logic        cnt_down = 1'b0;
    logic        pin_in = 1'b0;
    logic        pin_out;
    logic        pin_oe;
    logic        chan_flag;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    tmr_chan dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_en (reg_wr_en),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cnt_val   (cnt_val),
        .cnt_down  (cnt_down),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .chan_flag (chan_flag)
    );

    typedef struct packed {
        logic [7:0]  ctrl;
        logic [15:0] val;
        logic [15:0] start;
        logic [7:0]  steps;
        logic        pin;
        logic        oe;
        logic        flag;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{8'h05, 16'd5, 16'h0000, 8'd10, 1'b1, 1'b1, 1'b1},  // R3 toggle
        '{8'h07, 16'd5, 16'h0000, 8'd10, 1'b1, 1'b1, 1'b1},  // R3 set
        '{8'h06, 16'd5, 16'h0000, 8'd10, 1'b0, 1'b1, 1'b1},  // R3 clear
        '{8'h04, 16'd5, 16'h0000, 8'd10, 1'b0, 1'b0, 1'b1},  // R3 flag only
        '{8'h0A, 16'd5, 16'hFFFE, 8'd4,  1'b1, 1'b1, 1'b0},  // R4 high-true at zero
        '{8'h0A, 16'd5, 16'hFFFE, 8'd8,  1'b0, 1'b1, 1'b1},  // R4 high-true match
        '{8'h09, 16'd5, 16'hFFFE, 8'd4,  1'b0, 1'b1, 1'b0},  // R4 low-true at zero
        '{8'h09, 16'd5, 16'hFFFE, 8'd8,  1'b1, 1'b1, 1'b1},  // R4 low-true match
        '{8'h01, 16'd5, 16'h0000, 8'd10, 1'b0, 1'b0, 1'b0}   // R1 capture mode ignores match
    };

    function automatic string vec_req(input int i);
        if (i < 4) return "R3";
        if (i < 8) return "R4";
        return "R1";
    endfunction

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic reg_write(input logic sel, input logic [15:0] data);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_sel   = sel;
        reg_wdata = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic sel, output logic [15:0] data);
        @(negedge clk);
        reg_sel = sel;
        #1 data = reg_rdata;
    endtask

    task automatic step(input int n, input logic down);
        cnt_down = down;
        repeat (n) begin
            @(negedge clk);
            cnt_val = down ? cnt_val - 16'd1 : cnt_val + 16'd1;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;

        // R9 / R6: reset state
        do_reset();
        check("R9", "pin_out", {15'd0, pin_out}, 16'd0);
        check("R9", "pin_oe", {15'd0, pin_oe}, 16'd0);
        check("R9", "flag", {15'd0, chan_flag}, 16'd0);
        reg_read(1'b0, rd);
        check("R6", "ctrl after reset", rd, 16'h0000);
        reg_read(1'b1, rd);
        check("R6", "value after reset", rd, 16'h0000);

        // Vector table: compare, PWM and capture-mode runs
        for (int i = 0; i < NVEC; i++) begin
            do_reset();
            cnt_val  = VECS[i].start;
            cnt_down = 1'b0;
            repeat (2) @(negedge clk);
            reg_write(1'b0, {8'h00, VECS[i].ctrl});
            reg_write(1'b1, VECS[i].val);
            reg_write(1'b0, {8'h00, VECS[i].ctrl | 8'h80});
            step(VECS[i].steps, 1'b0);
            check(vec_req(i), $sformatf("vec%0d pin", i), {15'd0, pin_out}, {15'd0, VECS[i].pin});
            check(vec_req(i), $sformatf("vec%0d oe", i), {15'd0, pin_oe}, {15'd0, VECS[i].oe});
            check("R7", $sformatf("vec%0d flag", i), {15'd0, chan_flag}, {15'd0, VECS[i].flag});
        end

        // R6: register read/write
        do_reset();
        reg_write(1'b1, 16'hBEEF);
        reg_read(1'b1, rd);
        check("R6", "value readback", rd, 16'hBEEF);
        reg_write(1'b0, 16'h001F);
        reg_read(1'b0, rd);
        check("R6", "ctrl readback", rd, 16'h001F);
        do_reset();
        reg_read(1'b1, rd);
        check("R6", "value cleared by reset", rd, 16'h0000);

        // R1: rising-only capture
        do_reset();
        cnt_val = 16'h1234;
        reg_write(1'b0, 16'h0001);
        @(negedge clk);
        pin_in = 1'b1;
        repeat (3) @(negedge clk);
        reg_read(1'b1, rd);
        check("R1", "rise capture value", rd, 16'h1234);
        check("R1", "rise capture flag", {15'd0, chan_flag}, 16'd1);
        check("R1", "capture oe", {15'd0, pin_oe}, 16'd0);
        reg_write(1'b0, 16'h0081);
        check("R7", "flag cleared", {15'd0, chan_flag}, 16'd0);
        cnt_val = 16'h2222;
        pin_in  = 1'b0;
        repeat (4) @(negedge clk);
        reg_read(1'b1, rd);
        check("R1", "fall ignored value", rd, 16'h1234);
        check("R1", "fall ignored flag", {15'd0, chan_flag}, 16'd0);

        // R1: falling-only capture
        reg_write(1'b0, 16'h0002);
        cnt_val = 16'h3333;
        pin_in  = 1'b1;
        repeat (4) @(negedge clk);
        check("R1", "rise ignored flag", {15'd0, chan_flag}, 16'd0);
        pin_in = 1'b0;
        repeat (4) @(negedge clk);
        reg_read(1'b1, rd);
        check("R1", "fall capture value", rd, 16'h3333);

        // R1: both edges
        reg_write(1'b0, 16'h0083);
        cnt_val = 16'h4444;
        pin_in  = 1'b1;
        repeat (4) @(negedge clk);
        reg_read(1'b1, rd);
        check("R1", "both-edge capture value", rd, 16'h4444);
        pin_in = 1'b0;

        // R1: settled input on entering capture raises no flag
        do_reset();
        pin_in = 1'b1;
        repeat (4) @(negedge clk);
        reg_write(1'b0, 16'h0001);
        repeat (4) @(negedge clk);
        check("R1", "settled input no flag", {15'd0, chan_flag}, 16'd0);
        pin_in = 1'b0;

        // R2: released pin keeps level, oe low, flag still set
        do_reset();
        cnt_val = 16'h0000;
        reg_write(1'b0, 16'h0007);
        reg_write(1'b1, 16'd5);
        step(10, 1'b0);
        check("R3", "set before release", {15'd0, pin_out}, 16'd1);
        reg_write(1'b0, 16'h0084);
        cnt_val = 16'h0000;
        step(10, 1'b0);
        check("R2", "released pin held", {15'd0, pin_out}, 16'd1);
        check("R2", "released oe", {15'd0, pin_oe}, 16'd0);
        check("R7", "flag in flag-only compare", {15'd0, chan_flag}, 16'd1);

        // R8: held counter matches once
        do_reset();
        cnt_val = 16'd4;
        reg_write(1'b0, 16'h0005);
        reg_write(1'b1, 16'd5);
        @(negedge clk);
        cnt_val = 16'd5;
        repeat (5) @(negedge clk);
        check("R8", "single toggle on hold", {15'd0, pin_out}, 16'd1);

        // R7: event wins over clear; write with bit 7 low keeps flag
        do_reset();
        cnt_val = 16'd3;
        reg_write(1'b0, 16'h0004);
        reg_write(1'b1, 16'd5);
        @(negedge clk);
        cnt_val   = 16'd5;
        reg_wr_en = 1'b1;
        reg_sel   = 1'b0;
        reg_wdata = 16'h0084;
        @(negedge clk);
        reg_wr_en = 1'b0;
        check("R7", "event beats clear", {15'd0, chan_flag}, 16'd1);
        reg_write(1'b0, 16'h0004);
        check("R7", "bit7 low keeps flag", {15'd0, chan_flag}, 16'd1);
        reg_write(1'b0, 16'h0084);
        check("R7", "bit7 high clears", {15'd0, chan_flag}, 16'd0);

        // R5: centre-aligned high-true
        do_reset();
        cnt_val = 16'd8;
        reg_write(1'b0, 16'h0012);
        reg_write(1'b1, 16'd5);
        reg_write(1'b0, 16'h0092);
        step(5, 1'b1);
        check("R5", "high-true down match sets", {15'd0, pin_out}, 16'd1);
        check("R5", "down match flag", {15'd0, chan_flag}, 16'd1);
        reg_write(1'b0, 16'h0092);
        step(4, 1'b0);
        check("R5", "high-true up match clears", {15'd0, pin_out}, 16'd0);
        check("R5", "up match flag", {15'd0, chan_flag}, 16'd1);

        // R5: centre-aligned low-true, mode bits set but ignored
        do_reset();
        cnt_val = 16'd8;
        reg_write(1'b0, 16'h001D);
        reg_write(1'b1, 16'd5);
        step(5, 1'b1);
        check("R5", "low-true down match clears", {15'd0, pin_out}, 16'd0);
        step(4, 1'b0);
        check("R5", "low-true up match sets", {15'd0, pin_out}, 16'd1);
        check("R5", "centre oe", {15'd0, pin_oe}, 16'd1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule